// File: doc/BRIEF.md
# Complement-Paired Serial Number Locator

This block finds a device serial number that is kept in fuse memory as a record of two words. The first word holds the value and the second word holds its bitwise inverse. Records may have been written into several slots, so the block scans from the highest slot downwards and returns the newest record that passes the inverse check. A start strobe launches the scan. The block then issues one word read at a time on a plain request/response port, typically into a fuse sequencer. When the scan ends it reports the value, a flag that says whether a valid record was seen, and a one-cycle done pulse.

The first slot examined is the word pair at even index `START_IDX` (default 0xFE) and its odd neighbour. Each later slot sits two words lower. The lowest slot examined is the pair at index 2/3. If no slot is valid, the block returns the first word of that last pair with the found flag low. An error response from the reader aborts the scan.

Top module: `serial_pair_scanner`

## Requirements
- R1: A start pulse while idle begins a scan whose first read request carries index `START_IDX` (0xFE by default).
- R2: Within a slot the even word i is requested first and the odd word i+1 second. The next slot starts at i-2.
- R3: No read is ever issued below index 2, so the pair at 0/1 is never examined. The pair at 2/3 is the last one examined.
- R4: A slot is valid when word i equals the bitwise inverse of word i+1. The scan stops at the first valid slot, which is the highest-indexed one, and reports `serial` = word i with `found` = 1.
- R5: If no slot is valid, the scan ends after the pair at 2/3 with `serial` = word 2 and `found` = 0.
- R6: `rdReq` is a one-cycle pulse. At most one request is outstanding, and the next request is issued only after `rdAck` has returned the previous one.
- R7: A response with `rdErr` = 1 ends the scan at once: `done` pulses, `found` = 0 and `serial` = 0.
- R8: `busy` is high from the cycle after the accepted start until the end of the scan. `done` is a single-cycle pulse in the first cycle in which `busy` is low again.
- R9: A start pulse while `busy` is high has no effect: the read sequence and the result are the same as with no extra pulse.
- R10: After reset `busy`, `done`, `found` and `serial` are 0. `serial` and `found` change only in a `done` cycle and keep their values between scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| serial | output | DATA_W | Reported serial word |
| found | output | 1 | A valid complement pair ended the scan |
| rdReq | output | 1 | Word read request pulse |
| rdIdx | output | IDX_W | Word index of the request |
| rdAck | input | 1 | Read response valid |
| rdData | input | DATA_W | Read word, valid with rdAck |
| rdErr | input | 1 | Read response is an error, valid with rdAck |

## Verification
The hardest case to reach is a scan that walks all the way down to the 2/3 pair, because it needs a memory image in which no higher slot forms a complement pair. The bench fills its fuse model with a scrambled pattern that holds no valid pair. It then plants valid pairs one slot at a time across every slot from 0xFE down to 2, and also plants a decoy at a lower slot. A separate image holds a valid pair only at 0/1, which shows that this pair is never examined. Response latencies vary, start pulses are injected mid-scan, and error responses are placed on an odd-word read partway down.

// File: rtl/serial_scan_pkg.sv
package serial_scan_pkg;
  typedef struct packed {
    logic loadStart;
    logic captLo;
    logic selHi;
    logic stepDown;
    logic finishHit;
    logic finishMiss;
    logic finishErr;
  } scanCtrl_t;
endpackage

// File: rtl/serial_scan_ctrl.sv
module serial_scan_ctrl
  import serial_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rdAck,
  input  logic      rdErr,
  input  logic      pairOk,
  input  logic      atLast,
  output logic      busy,
  output logic      rdReq,
  output scanCtrl_t ctl
);
  typedef enum logic [2:0] {S_IDLE, S_REQ_LO, S_WAIT_LO, S_REQ_HI, S_WAIT_HI} scanState_t;
  scanState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    rdReq     = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.loadStart = 1'b1;
        nextState     = S_REQ_LO;
      end
      S_REQ_LO: begin
        rdReq     = 1'b1;
        nextState = S_WAIT_LO;
      end
      S_WAIT_LO: if (rdAck) begin
        if (rdErr) begin
          ctl.finishErr = 1'b1;
          nextState     = S_IDLE;
        end else begin
          ctl.captLo = 1'b1;
          nextState  = S_REQ_HI;
        end
      end
      S_REQ_HI: begin
        ctl.selHi = 1'b1;
        rdReq     = 1'b1;
        nextState = S_WAIT_HI;
      end
      S_WAIT_HI: if (rdAck) begin
        if (rdErr) begin
          ctl.finishErr = 1'b1;
          nextState     = S_IDLE;
        end else if (pairOk) begin
          ctl.finishHit = 1'b1;
          nextState     = S_IDLE;
        end else if (atLast) begin
          ctl.finishMiss = 1'b1;
          nextState      = S_IDLE;
        end else begin
          ctl.stepDown = 1'b1;
          nextState    = S_REQ_LO;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/serial_scan_dp.sv
module serial_scan_dp
  import serial_scan_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int DATA_W    = 32,
  parameter int START_IDX = 254,
  parameter int STOP_IDX  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtrl_t         ctl,
  input  logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              pairOk,
  output logic              atLast,
  output logic [DATA_W-1:0] serial,
  output logic              found,
  output logic              done
);
  localparam logic [IDX_W-1:0] StartIdx = IDX_W'(START_IDX);
  localparam logic [IDX_W-1:0] StopIdx  = IDX_W'(STOP_IDX);
  localparam logic [IDX_W-1:0] Stride   = IDX_W'(2);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] loWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      loWord <= '0;
      serial <= '0;
      found  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.loadStart) idx <= StartIdx;
      if (ctl.stepDown)  idx <= idx - Stride;
      if (ctl.captLo)    loWord <= rdData;
      if (ctl.finishHit) begin
        serial <= loWord;
        found  <= 1'b1;
        done   <= 1'b1;
      end
      if (ctl.finishMiss) begin
        serial <= loWord;
        found  <= 1'b0;
        done   <= 1'b1;
      end
      if (ctl.finishErr) begin
        serial <= '0;
        found  <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign rdIdx  = {idx[IDX_W-1:1], ctl.selHi};
  assign pairOk = (loWord == ~rdData);
  assign atLast = (idx == StopIdx);
endmodule

// File: rtl/serial_pair_scanner.sv
module serial_pair_scanner
  import serial_scan_pkg::*;
#(
  parameter int IDX_W     = 12,
  parameter int DATA_W    = 32,
  parameter int START_IDX = 254,
  parameter int STOP_IDX  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] serial,
  output logic              found,
  output logic              rdReq,
  output logic [IDX_W-1:0]  rdIdx,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdErr
);
  scanCtrl_t ctl;
  logic      pairOk;
  logic      atLast;

  serial_scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck), .rdErr(rdErr),
    .pairOk(pairOk), .atLast(atLast), .busy(busy), .rdReq(rdReq), .ctl(ctl)
  );

  serial_scan_dp #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .START_IDX(START_IDX), .STOP_IDX(STOP_IDX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(rdData), .rdIdx(rdIdx),
    .pairOk(pairOk), .atLast(atLast), .serial(serial), .found(found), .done(done)
  );
endmodule

// File: rtl/serial_pair_scanner_chk.sv
module serial_pair_scanner_chk #(
  parameter int IDX_W     = 12,
  parameter int DATA_W    = 32,
  parameter int START_IDX = 254,
  parameter int STOP_IDX  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] serial,
  input logic              found,
  input logic              rdReq,
  input logic [IDX_W-1:0]  rdIdx
);
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> busy); // R6
  AST_REQ_IS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq); // R6
  AST_IDX_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdIdx >= IDX_W'(STOP_IDX)) && (rdIdx <= IDX_W'(START_IDX + 1))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(serial) && $stable(found))); // R10
endmodule

bind serial_pair_scanner serial_pair_scanner_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .START_IDX(START_IDX), .STOP_IDX(STOP_IDX)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .serial(serial),
  .found(found), .rdReq(rdReq), .rdIdx(rdIdx)
);

// File: tb/serial_pair_scanner_tb.sv
`timescale 1ns/1ps
module serial_pair_scanner_tb;
  localparam int IDX_W = 12;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, found, rdReq;
  logic [DATA_W-1:0] serial;
  logic [IDX_W-1:0] rdIdx;
  logic rdAck = 1'b0;
  logic rdErr = 1'b0;
  logic [DATA_W-1:0] rdData = '0;

  always #2.5 clk = ~clk;

  serial_pair_scanner u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .serial(serial), .found(found), .rdReq(rdReq), .rdIdx(rdIdx),
    .rdAck(rdAck), .rdData(rdData), .rdErr(rdErr)
  );

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] mem [256];
  logic [IDX_W-1:0] readLog [512];
  int nReads = 0;
  int overlaps = 0;
  int lat = 0;
  bit errEn = 0;
  int errIdx = 0;
  bit pending = 0;
  int waitCnt = 0;
  logic [IDX_W-1:0] pIdx;

  // fuse model: responds lat+1 cycles after a request
  always @(negedge clk) begin
    rdAck = 1'b0;
    rdErr = 1'b0;
    if (pending) begin
      if (waitCnt == 0) begin
        rdAck = 1'b1;
        rdData = mem[pIdx[7:0]];
        rdErr = errEn && (int'(pIdx) == errIdx);
        pending = 0;
      end else waitCnt--;
    end
    if (rdReq) begin
      if (pending) overlaps++;
      pending = 1;
      pIdx = rdIdx;
      waitCnt = lat;
      if (nReads < 512) readLog[nReads] = rdIdx;
      nReads++;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] scramble(input int k);
    return (DATA_W'(k) * 32'h9E37_79B9) ^ 32'h5A5A_1234;
  endfunction

  task automatic fillBase();
    for (int k = 0; k < 256; k++) mem[k] = scramble(k);
  endtask

  // reference model of the scan
  logic [DATA_W-1:0] expSerial;
  bit expFound;
  int expReads;
  task automatic model();
    expSerial = '0; expFound = 0; expReads = 0;
    for (int i = 254; i >= 2; i -= 2) begin
      expReads++;
      if (errEn && errIdx == i) begin expSerial = '0; return; end
      expSerial = mem[i];
      expReads++;
      if (errEn && errIdx == i + 1) begin expSerial = '0; return; end
      if (mem[i] == ~mem[i+1]) begin expFound = 1; return; end
    end
  endtask

  task automatic runScan(input string req, input int extraStartAt);
    int cyc;
    bit orderOk;
    model();
    nReads = 0; overlaps = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R8", "busy after start", busy, 1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == extraStartAt) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(req, "done seen", done, 1);
    check(req, "busy low at done", busy, 0);
    check(req, "serial", serial, expSerial);
    check(req, "found", found, expFound);
    check("R9", "read count", nReads, expReads);
    check("R6", "overlapping requests", overlaps, 0);
    orderOk = 1;
    for (int r = 0; r < nReads && r < 512; r++)
      if (int'(readLog[r]) != 254 - 2 * (r / 2) + (r % 2)) orderOk = 0;
    check("R2", "read order", orderOk, 1);
    @(negedge clk);
    check("R8", "done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] held;
    fillBase();
    repeat (3) @(negedge clk);
    check("R10", "reset busy", busy, 0);
    check("R10", "reset done", done, 0);
    check("R10", "reset found", found, 0);
    check("R10", "reset serial", serial, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: no valid slot anywhere
    fillBase();
    runScan("R5", 0);
    check("R5", "serial is word 2", serial, mem[2]);
    check("R1", "first index", readLog[0], 254);
    check("R3", "last index", readLog[nReads-1], 3);

    // R3: only pair 0/1 valid
    fillBase();
    mem[1] = ~mem[0];
    runScan("R3", 0);
    check("R3", "pair 0/1 ignored", found, 0);

    // R10: result holds between scans
    held = serial;
    mem[2] = 32'hDEAD_BEEF;
    repeat (20) @(negedge clk);
    check("R10", "serial held", serial, held);

    // R4: sweep every slot, decoy below
    for (int p = 1; p <= 127; p++) begin
      fillBase();
      lat = p % 3;
      mem[2*p] = 32'hC0DE_0000 + DATA_W'(p);
      mem[2*p+1] = ~mem[2*p];
      if (p > 1) begin mem[2] = 32'h0BAD_0BAD; mem[3] = ~mem[2]; end
      runScan("R4", 0);
      check("R4", "picked slot", serial, 32'hC0DE_0000 + DATA_W'(p));
    end

    // R9: start while busy
    fillBase(); lat = 1;
    mem[100] = 32'h1357_2468; mem[101] = ~mem[100];
    runScan("R9", 7);
    fillBase(); lat = 0;
    runScan("R9", 40);

    // R7: error responses
    fillBase(); lat = 2;
    errEn = 1; errIdx = 241;
    runScan("R7", 0);
    check("R7", "err reads", nReads, 16);
    check("R7", "err serial", serial, 0);
    errIdx = 254;
    mem[254] = 32'h1; mem[255] = ~32'h1;
    runScan("R7", 0);
    check("R7", "err on first read", found, 0);
    errEn = 0;
    runScan("R4", 0);
    check("R4", "top slot after error", serial, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule